// File: doc/BRIEF.md
# Per-Line Modem Status Keeper

This block holds the modem status of a small group of serial lines. For each line it keeps a ring indication and a carrier indication, both presented in one read-only status word. Ring indications sit in the lower half of the word, with line i at bit i. Carrier indications sit in the upper half, with line i at bit NLINES+i.

The block also owns a line control word that software writes. Its lower half holds per-line transmit enables. Its upper half holds per-line terminal-ready (DTR) bits, with line i at bit NLINES+i. The status bits change when a remote end connects or disconnects, and when software writes a new set of DTR bits. When the automatic hang-up option is on, dropping DTR on a connected line ends that connection and raises a one-cycle hang-up pulse for that line.

The status word only moves while modem handling is enabled. The line control word can be cleared in two ways. A soft clear empties the transmit enables and keeps DTR. Reset clears the whole word.

Top module: `mdm_status_top`

## Requirements
- R1: After reset, `status_o`, `ctl_o` and `hangup_o` are all zero.
- R2: With `mctl_en` high, a connect pulse on line i sets carrier bit NLINES+i in the next cycle if that line's DTR bit (as of that cycle's write) is 1. If the DTR bit is 0, it sets ring bit i instead.
- R3: With `mctl_en` high, any write to the control word sets carrier bit NLINES+i for every line whose new DTR bit and current ring bit are both 1. The same write clears ring bit i for every line whose new DTR bit is 1.
- R4: With `mctl_en` and `auto_en` high, a write that takes the DTR bit of a connected line from 1 to 0 has three effects. It gives `hangup_o[i]` high for exactly the next cycle, it clears that line's carrier bit, and it marks the line disconnected. With `auto_en` low, no hang-up occurs and the carrier bit is kept.
- R5: With `mctl_en` high, the carrier bit of every line that is not connected reads 0 in the next cycle. A disconnect pulse marks its line not connected.
- R6: While `mctl_en` is low, `status_o` holds its value and `hangup_o` stays 0. Connection tracking and control-word writes still take effect.
- R7: `wr_en[0]` loads `wr_data[NLINES-1:0]` into the transmit-enable half of `ctl_o`. `wr_en[1]` loads `wr_data[2*NLINES-1:NLINES]` into the DTR half. A half whose enable is low keeps its value. Both halves show in `ctl_o` one cycle later.
- R8: `dev_clr` zeroes the transmit-enable half of `ctl_o` and leaves the DTR half unchanged. If a write arrives in the same cycle, the write is applied first and the clear is applied after it.
- R9: Events in the same cycle are applied in this order: disconnect, then control write, then connect. A disconnect and a connect together leave the line connected. A hang-up and a connect together leave it connected with the ring bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, clears everything |
| mctl_en | input | 1 | Modem status handling enable |
| auto_en | input | 1 | Automatic hang-up on DTR drop |
| conn_p | input | NLINES | Per-line connect pulse |
| disc_p | input | NLINES | Per-line disconnect pulse |
| wr_en | input | 2 | Control-word write enables, one per half |
| wr_data | input | 2*NLINES | Control-word write data |
| dev_clr | input | 1 | Soft clear of transmit enables |
| ctl_o | output | 2*NLINES | Line control word (DTR upper, transmit enables lower) |
| status_o | output | 2*NLINES | Modem status (carrier upper, ring lower) |
| hangup_o | output | NLINES | Per-line hang-up pulse |

## Verification
The connected flag is not visible at the ports, so a wrong flag shows up only later, through the status word. It appears in the next cycle as a carrier bit that survives a disconnect. It can also appear many cycles later, as a missing or spurious hang-up pulse when DTR falls. A stale ring bit shows up only at the next control write, as a carrier that should or should not have been granted. For this reason the bench runs a reference model over long random event streams and compares all three outputs in every cycle. This catches a divergence in the cycle it first reaches the ports.

// File: rtl/mdm_pkg.sv
package mdm_pkg;
   // Upper bound on line count; ring and carrier halves must fit the word.
   localparam int MAX_LINES = 16;

   // How the hang-up pulse leaves a line slice.
   typedef enum logic {
      HANG_REG  = 1'b0,
      HANG_COMB = 1'b1
   } hang_style_e;
endpackage

// File: rtl/mdm_ctl_reg.sv
module mdm_ctl_reg #(
   parameter int NLINES = 8
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [1:0]            wr_en,
   input  logic [2*NLINES-1:0]   wr_data,
   input  logic                  dev_clr,
   output logic [2*NLINES-1:0]   ctl_q,
   output logic                  wr_any,
   output logic [NLINES-1:0]     dtr_old,
   output logic [NLINES-1:0]     dtr_new
);
   localparam int CW = 2 * NLINES;

   logic [CW-1:0] merged;
   logic [CW-1:0] nxt;

   // One half per write enable.
   for (genvar h = 0; h < 2; h++) begin : g_half
      assign merged[h*NLINES +: NLINES] =
         wr_en[h] ? wr_data[h*NLINES +: NLINES] : ctl_q[h*NLINES +: NLINES];
   end

   always_comb begin
      nxt = merged;
      if (dev_clr) nxt[NLINES-1:0] = '0;   // soft clear after the write
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ctl_q <= '0;
      else        ctl_q <= nxt;
   end

   assign wr_any  = |wr_en;
   assign dtr_old = ctl_q[CW-1:NLINES];
   assign dtr_new = merged[CW-1:NLINES];

   a_r8_clear_empties_low: assert property (@(posedge clk) disable iff (!rst_n)
      dev_clr |=> ctl_q[NLINES-1:0] == '0);
   a_r8_clear_keeps_dtr: assert property (@(posedge clk) disable iff (!rst_n)
      (dev_clr && !wr_en[1]) |=> $stable(ctl_q[CW-1:NLINES]));
   a_r7_high_half_loads: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en[1] |=> ctl_q[CW-1:NLINES] == $past(wr_data[CW-1:NLINES]));
endmodule

// File: rtl/mdm_line.sv
module mdm_line #(
   parameter mdm_pkg::hang_style_e STYLE = mdm_pkg::HANG_REG
) (
   input  logic clk,
   input  logic rst_n,
   input  logic mctl_en,
   input  logic auto_en,
   input  logic con_p,
   input  logic dis_p,
   input  logic wr_any,
   input  logic dtr_old,
   input  logic dtr_new,
   output logic ring_o,
   output logic car_o,
   output logic hang_o
);
   logic ring_q, car_q, conn_q;
   logic ring_d, car_d, conn_d, hang_d;

   // Order inside one cycle: disconnect, write, connect, carrier sweep.
   always_comb begin
      conn_d = conn_q & ~dis_p;
      ring_d = ring_q;
      car_d  = car_q;
      hang_d = 1'b0;
      if (mctl_en && wr_any) begin
         if (dtr_new) begin
            car_d  = car_d | ring_q;
            ring_d = 1'b0;
         end
         if (auto_en && dtr_old && !dtr_new && conn_d) begin
            hang_d = 1'b1;
            car_d  = 1'b0;
            conn_d = 1'b0;
         end
      end
      if (con_p) begin
         conn_d = 1'b1;
         if (mctl_en) begin
            if (dtr_new) car_d  = 1'b1;
            else         ring_d = 1'b1;
         end
      end
      if (mctl_en) car_d = car_d & conn_d;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ring_q <= 1'b0;
         car_q  <= 1'b0;
         conn_q <= 1'b0;
      end else begin
         ring_q <= ring_d;
         car_q  <= car_d;
         conn_q <= conn_d;
      end
   end

   assign ring_o = ring_q;
   assign car_o  = car_q;

   generate
      if (STYLE == mdm_pkg::HANG_REG) begin : g_hang_reg
         logic hang_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) hang_q <= 1'b0;
            else        hang_q <= hang_d;
         end
         assign hang_o = hang_q;

         a_r4_hang_needs_enables: assert property (@(posedge clk) disable iff (!rst_n)
            hang_q |-> $past(mctl_en && auto_en && wr_any && dtr_old));
         a_r4_hang_drops_carrier: assert property (@(posedge clk) disable iff (!rst_n)
            hang_q |-> !car_q);
      end else begin : g_hang_comb
         assign hang_o = hang_d;
      end
   endgenerate

   a_r5_carrier_needs_conn: assert property (@(posedge clk) disable iff (!rst_n)
      mctl_en |=> !(car_q && !conn_q));
   a_r2_connect_grants_carrier: assert property (@(posedge clk) disable iff (!rst_n)
      (mctl_en && con_p && !wr_any && dtr_old) |=> car_q);
endmodule

// File: rtl/mdm_status_top.sv
module mdm_status_top #(
   parameter int                   NLINES     = 8,
   parameter mdm_pkg::hang_style_e HANG_STYLE = mdm_pkg::HANG_REG
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  mctl_en,
   input  logic                  auto_en,
   input  logic [NLINES-1:0]     conn_p,
   input  logic [NLINES-1:0]     disc_p,
   input  logic [1:0]            wr_en,
   input  logic [2*NLINES-1:0]   wr_data,
   input  logic                  dev_clr,
   output logic [2*NLINES-1:0]   ctl_o,
   output logic [2*NLINES-1:0]   status_o,
   output logic [NLINES-1:0]     hangup_o
);
   localparam int CW = 2 * NLINES;

   if (NLINES < 1 || NLINES > mdm_pkg::MAX_LINES) begin : g_bad_lines
      $error("mdm_status_top: NLINES out of range");
   end

   logic              wr_any;
   logic [NLINES-1:0] dtr_old, dtr_new, ring, car;

   mdm_ctl_reg #(.NLINES(NLINES)) u_ctl (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_data (wr_data),
      .dev_clr (dev_clr),
      .ctl_q   (ctl_o),
      .wr_any  (wr_any),
      .dtr_old (dtr_old),
      .dtr_new (dtr_new)
   );

   for (genvar i = 0; i < NLINES; i++) begin : g_line
      mdm_line #(.STYLE(HANG_STYLE)) u_line (
         .clk     (clk),
         .rst_n   (rst_n),
         .mctl_en (mctl_en),
         .auto_en (auto_en),
         .con_p   (conn_p[i]),
         .dis_p   (disc_p[i]),
         .wr_any  (wr_any),
         .dtr_old (dtr_old[i]),
         .dtr_new (dtr_new[i]),
         .ring_o  (ring[i]),
         .car_o   (car[i]),
         .hang_o  (hangup_o[i])
      );
   end

   assign status_o = {car, ring};

   a_r6_status_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      !mctl_en |=> $stable(status_o));
   a_r3_dtr_clears_ring: assert property (@(posedge clk) disable iff (!rst_n)
      (mctl_en && wr_en[1] && conn_p == '0) |=>
         (status_o[NLINES-1:0] & ctl_o[CW-1:NLINES]) == '0);
endmodule

// File: tb/sim_mdm_status_top.sv
module sim_mdm_status_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        mctl_en = 1'b0, auto_en = 1'b0, dev_clr = 1'b0;
   logic [7:0]  conn_p = '0, disc_p = '0;
   logic [1:0]  wr_en = '0;
   logic [15:0] wr_data = '0;
   logic [15:0] ctl_o, status_o;
   logic [7:0]  hangup_o;

   int n_chk = 0, n_bad = 0;
   bit done = 0;

   // reference state
   logic [15:0] m_ctl = '0;
   logic [7:0]  m_ring = '0, m_car = '0, m_conn = '0, m_hang = '0;

   always #5 clk = ~clk;

   mdm_status_top u0 (
      .clk(clk), .rst_n(rst_n), .mctl_en(mctl_en), .auto_en(auto_en),
      .conn_p(conn_p), .disc_p(disc_p), .wr_en(wr_en), .wr_data(wr_data),
      .dev_clr(dev_clr), .ctl_o(ctl_o), .status_o(status_o), .hangup_o(hangup_o)
   );

   task automatic check(input string tag, input string what,
                        input logic [15:0] act, input logic [15:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
      end
   endtask

   task automatic compare(input string tag);
      check(tag, "ctl",    ctl_o,              m_ctl);
      check(tag, "status", status_o,           {m_car, m_ring});
      check(tag, "hangup", {8'h00, hangup_o},  {8'h00, m_hang});
   endtask

   // One clock: drive at negedge, update model, compare at next negedge.
   task automatic cyc(input string tag, input logic m, input logic a,
                      input logic [7:0] con, input logic [7:0] dis,
                      input logic [1:0] we, input logic [15:0] wd, input logic clr);
      logic [15:0] nctl;
      logic [7:0]  c, r, k, h, dold, dnew;
      mctl_en = m; auto_en = a; conn_p = con; disc_p = dis;
      wr_en = we; wr_data = wd; dev_clr = clr;
      c = m_conn & ~dis;
      nctl = m_ctl;
      if (we[0]) nctl[7:0]  = wd[7:0];
      if (we[1]) nctl[15:8] = wd[15:8];
      dold = m_ctl[15:8]; dnew = nctl[15:8];
      r = m_ring; k = m_car; h = '0;
      if (m && (we != 2'b00)) begin
         k = k | (dnew & r);
         r = r & ~dnew;
         if (a) begin
            h = dold & ~dnew & c;
            k = k & ~h;
            c = c & ~h;
         end
      end
      c = c | con;
      if (m) begin
         k = k | (con & dnew);
         r = r | (con & ~dnew);
         k = k & c;
      end
      if (clr) nctl[7:0] = '0;
      @(negedge clk);
      m_ctl = nctl; m_ring = r; m_car = k; m_conn = c; m_hang = h;
      compare(tag);
   endtask

   task automatic idle(input string tag, input logic m, input logic a);
      cyc(tag, m, a, 8'h00, 8'h00, 2'b00, 16'h0000, 1'b0);
   endtask

   initial begin : watchdog
      #2_000_000;
      if (!done) begin
         n_bad++;
         $display("FAIL R1 watchdog actual=timeout expected=finish");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin : main
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1: reset state
      compare("R1");
      idle("R1", 1'b1, 1'b0);

      // R2: connect with DTR low -> ring; with DTR high -> carrier
      cyc("R2", 1, 0, 8'h01, 8'h00, 2'b00, 16'h0000, 0);
      check("R2", "ring0", {15'd0, status_o[0]}, 16'd1);
      cyc("R2", 1, 0, 8'h00, 8'h00, 2'b10, 16'h0200, 0);
      cyc("R2", 1, 0, 8'h02, 8'h00, 2'b00, 16'h0000, 0);
      check("R2", "car1", {15'd0, status_o[9]}, 16'd1);

      // R3: raising DTR on ringing line promotes it to carrier
      cyc("R3", 1, 0, 8'h00, 8'h00, 2'b10, 16'h0300, 0);
      check("R3", "car0", {15'd0, status_o[8]}, 16'd1);
      check("R3", "ring0", {15'd0, status_o[0]}, 16'd0);

      // R4: auto hang-up on falling DTR of connected line 0
      cyc("R4", 1, 1, 8'h00, 8'h00, 2'b10, 16'h0200, 0);
      check("R4", "hang0", {8'd0, hangup_o}, 16'h0001);
      idle("R4", 1, 1);
      check("R4", "hang pulse ends", {8'd0, hangup_o}, 16'h0000);
      // without auto_en: dropping DTR of line1 keeps carrier
      cyc("R4", 1, 0, 8'h00, 8'h00, 2'b10, 16'h0000, 0);
      check("R4", "car1 kept", {15'd0, status_o[9]}, 16'd1);

      // R5: disconnect clears carrier
      cyc("R5", 1, 0, 8'h00, 8'h02, 2'b00, 16'h0000, 0);
      check("R5", "car1", {15'd0, status_o[9]}, 16'd0);

      // R6: modem handling off freezes status
      cyc("R6", 0, 1, 8'h04, 8'h00, 2'b10, 16'hFF00, 0);
      cyc("R6", 0, 1, 8'h00, 8'h00, 2'b10, 16'h0000, 0);
      check("R6", "no hangup", {8'd0, hangup_o}, 16'h0000);
      idle("R6", 1, 0);

      // R7: half writes
      cyc("R7", 1, 0, 8'h00, 8'h00, 2'b01, 16'hA55A, 0);
      cyc("R7", 1, 0, 8'h00, 8'h00, 2'b10, 16'h3CC3, 0);
      cyc("R7", 1, 0, 8'h00, 8'h00, 2'b11, 16'h8001, 0);

      // R8: soft clear keeps DTR, and wins over same-cycle low write
      cyc("R8", 1, 0, 8'h00, 8'h00, 2'b11, 16'hF00F, 0);
      cyc("R8", 1, 0, 8'h00, 8'h00, 2'b00, 16'h0000, 1);
      check("R8", "ctl", ctl_o, 16'hF000);
      cyc("R8", 1, 0, 8'h00, 8'h00, 2'b11, 16'h0FFF, 1);

      // R9: same-cycle ordering
      cyc("R9", 1, 0, 8'h08, 8'h00, 2'b10, 16'h0800, 0);
      cyc("R9", 1, 0, 8'h08, 8'h08, 2'b00, 16'h0000, 0);
      check("R9", "car3 after dis+con", {15'd0, status_o[11]}, 16'd1);
      cyc("R9", 1, 1, 8'h08, 8'h00, 2'b10, 16'h0000, 0);
      check("R9", "hang3", {8'd0, hangup_o}, 16'h0008);
      check("R9", "ring3", {15'd0, status_o[3]}, 16'd1);
      check("R9", "car3", {15'd0, status_o[11]}, 16'd0);

      // R9: random sweep against the model, all event mixes
      for (int i = 0; i < 4000; i++) begin
         logic [7:0] con, dis;
         logic [1:0] we;
         con = ($urandom_range(0, 3) == 0) ? 8'($urandom) & 8'($urandom) : 8'h00;
         dis = ($urandom_range(0, 3) == 0) ? 8'($urandom) & 8'($urandom) : 8'h00;
         we  = ($urandom_range(0, 2) == 0) ? 2'($urandom) : 2'b00;
         cyc("R9", ($urandom_range(0, 7) != 0), 1'($urandom), con, dis, we,
             16'($urandom), ($urandom_range(0, 15) == 0));
      end

      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule